// File: doc/BRIEF.md
# Timer Channel Counter with Sticky Wrap Flags

One channel of a 16-bit timer. The counter can be loaded with a preset value. When enabled, it steps by one on each clock. It counts up by default. It counts down only when the channel supports a down-counting mode that is selected and the direction input asks for down. Channels 1 and 2 support the phase-counting mode, and channel 4 supports the complementary PWM mode. The block watches each step for a wrap-around. It records wraps in sticky flags that software reads through an 8-bit status register. The channel number is a compile-time parameter. It decides which status bits are live and which are fixed constants.

Software clears a flag with a read-then-write sequence. A read that sees a flag at 1 arms that flag. The next write to the status register uses up every arm, and a 0 written to an armed flag clears that flag. On channel 4, an acknowledge from a transfer controller can also clear the overflow flag. A second register holds the interrupt enables. Each interrupt output is its flag gated by its enable.

Top module: `tmr_chan_status`

## Requirements
- R1: After reset, the status register (regSel=0) reads 0xC0, the count is 0, the enable register (regSel=1) reads 0x00 and both interrupt outputs are 0.
- R2: Status bit 7 is 1 while the counter steps upward and 0 after a downward step. It takes a new value only on a clock where counting is enabled. Writes to it are ignored. On channel 0 it always reads 1.
- R3: Status bit 6 always reads 1, and status bits 3..0 always read 0.
- R4: Status bit 4 (overflow) becomes 1 on the clock where the count steps from 0xFFFF to 0x0000.
- R5: On channels 1 and 2 in phase-counting mode, status bit 5 (underflow) becomes 1 when the count steps from 0x0000 to 0xFFFF. On channels 0, 3 and 4, bit 5 always reads 0.
- R6: On channel 4 in complementary PWM mode, a downward step from 0x0001 to 0x0000 sets the overflow flag.
- R7: A status write clears a flag only where it writes 0 to a flag that an earlier status read returned as 1. Writing 1 has no effect, a write with no prior read has no effect, and every status write uses up all arms.
- R8: When a set event and a clear request fall on the same clock, the flag ends at 1.
- R9: On channel 4, xferAck with disableSel=0 clears the overflow flag. With disableSel=1 it has no effect.
- R10: The enable register sits at regSel=1 (bit 0 overflow, bit 1 underflow). irqOvf and irqUnf each equal the flag ANDed with its enable bit.
- R11: loadEn loads loadValue, and it takes priority over counting. With cntEnable=1 the count moves by one per clock. With cntEnable=0 it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEnable | input | 1 | Count step enable |
| countUp | input | 1 | Requested direction, 1 = up |
| phaseMode | input | 1 | Phase-counting mode select |
| cplPwmMode | input | 1 | Complementary PWM mode select |
| loadEn | input | 1 | Load preset into counter |
| loadValue | input | 16 | Preset value |
| regSel | input | 1 | 0 = status register, 1 = enable register |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of selected register |
| xferAck | input | 1 | Transfer controller acknowledge for overflow |
| disableSel | input | 1 | Acknowledge clear disable select |
| count | output | 16 | Current counter value |
| irqOvf | output | 1 | Overflow interrupt |
| irqUnf | output | 1 | Underflow interrupt |

## Verification
The hardest case to reach is a set event and an armed software clear on the same clock. First the overflow flag must be 1. Then a read must arm it. Then the count must be parked at 0xFFFF with counting stopped, so that the arm is not used up. The bench does this with a preset load and a separate read. After that, one clock carries both the enabling step and the clearing write. The channel-4 behaviour (the down step from 0x0001 to 0x0000 and the acknowledge clear) is reached by running a second instance from the same stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       clrOvf;
    logic       clrUnf;
    logic       ienWr;
    logic [1:0] ienData;
  } ctlStrobes_t;
endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
#(
  parameter int CHAN = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regRd,
  input  logic        regWr,
  input  logic [7:0]  regWdata,
  input  logic        ovfFlag,
  input  logic        unfFlag,
  input  logic        xferAck,
  input  logic        disableSel,
  output ctlStrobes_t stb
);
  localparam bit HAS_ACK = (CHAN == 4);

  logic armOvf, armUnf;
  logic stRd, stWr, ackClr;

  assign stRd = regRd && !regSel;
  assign stWr = regWr && !regSel;

  generate
    if (HAS_ACK) begin : g_ack
      assign ackClr = xferAck && !disableSel;
    end else begin : g_noack
      assign ackClr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armOvf <= 1'b0;
      armUnf <= 1'b0;
    end else begin
      if (stRd && ovfFlag) armOvf <= 1'b1;
      else if (stWr)       armOvf <= 1'b0;
      if (stRd && unfFlag) armUnf <= 1'b1;
      else if (stWr)       armUnf <= 1'b0;
    end
  end

  always_comb begin
    stb.clrOvf  = (stWr && armOvf && !regWdata[4]) || ackClr;
    stb.clrUnf  = stWr && armUnf && !regWdata[5];
    stb.ienWr   = regWr && regSel;
    stb.ienData = regWdata[1:0];
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CHAN = 1,
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntEnable,
  input  logic          countUp,
  input  logic          phaseMode,
  input  logic          cplPwmMode,
  input  logic          loadEn,
  input  logic [CW-1:0] loadValue,
  input  ctlStrobes_t   stb,
  output logic [CW-1:0] count,
  output logic          ovfFlag,
  output logic          unfFlag,
  output logic          dirUp,
  output logic          ienOvf,
  output logic          ienUnf
);
  localparam bit HAS_DIR = (CHAN != 0);
  localparam bit HAS_UNF = (CHAN == 1) || (CHAN == 2);
  localparam bit HAS_CPL = (CHAN == 4);
  localparam logic [CW-1:0] TOP = '1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic downOk, goDown, step, ovfEvt, unfEvt;

  assign downOk = (HAS_UNF && phaseMode) || (HAS_CPL && cplPwmMode);
  assign goDown = downOk && !countUp;
  assign step   = cntEnable && !loadEn;
  assign ovfEvt = step && ((!goDown && count == TOP) ||
                           (HAS_CPL && cplPwmMode && goDown && count == ONE));
  assign unfEvt = step && HAS_UNF && phaseMode && goDown && count == '0;

  always_ff @(posedge clk) begin
    if (!rstN)       count <= '0;
    else if (loadEn) count <= loadValue;
    else if (step)   count <= goDown ? count - ONE : count + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ovfFlag <= 1'b0;
    else if (ovfEvt)      ovfFlag <= 1'b1;
    else if (stb.clrOvf)  ovfFlag <= 1'b0;
  end

  generate
    if (HAS_UNF) begin : g_unf
      always_ff @(posedge clk) begin
        if (!rstN)           unfFlag <= 1'b0;
        else if (unfEvt)     unfFlag <= 1'b1;
        else if (stb.clrUnf) unfFlag <= 1'b0;
      end
    end else begin : g_nounf
      assign unfFlag = 1'b0;
    end

    if (HAS_DIR) begin : g_dir
      always_ff @(posedge clk) begin
        if (!rstN)          dirUp <= 1'b1;
        else if (cntEnable) dirUp <= !goDown;
      end
    end else begin : g_nodir
      assign dirUp = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienOvf <= 1'b0;
      ienUnf <= 1'b0;
    end else if (stb.ienWr) begin
      ienOvf <= stb.ienData[0];
      ienUnf <= stb.ienData[1];
    end
  end
endmodule

// File: rtl/tmr_chan_status.sv
module tmr_chan_status
  import tmr_pkg::*;
#(
  parameter int CHAN = 1,
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntEnable,
  input  logic          countUp,
  input  logic          phaseMode,
  input  logic          cplPwmMode,
  input  logic          loadEn,
  input  logic [CW-1:0] loadValue,
  input  logic          regSel,
  input  logic          regRd,
  input  logic          regWr,
  input  logic [7:0]    regWdata,
  output logic [7:0]    regRdata,
  input  logic          xferAck,
  input  logic          disableSel,
  output logic [CW-1:0] count,
  output logic          irqOvf,
  output logic          irqUnf
);
  ctlStrobes_t stb;
  logic ovfFlag, unfFlag, dirUp, ienOvf, ienUnf;

  tmr_ctl #(.CHAN(CHAN)) u_ctl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .ovfFlag(ovfFlag), .unfFlag(unfFlag),
    .xferAck(xferAck), .disableSel(disableSel), .stb(stb)
  );

  tmr_datapath #(.CHAN(CHAN), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .countUp(countUp),
    .phaseMode(phaseMode), .cplPwmMode(cplPwmMode), .loadEn(loadEn),
    .loadValue(loadValue), .stb(stb), .count(count), .ovfFlag(ovfFlag),
    .unfFlag(unfFlag), .dirUp(dirUp), .ienOvf(ienOvf), .ienUnf(ienUnf)
  );

  assign regRdata = regSel ? {6'b0, ienUnf, ienOvf}
                           : {dirUp, 1'b1, unfFlag, ovfFlag, 4'b0};
  assign irqOvf = ovfFlag && ienOvf;
  assign irqUnf = unfFlag && ienUnf;
endmodule

// File: rtl/tmr_chan_status_chk.sv
module tmr_chan_status_chk #(
  parameter int CHAN = 1,
  parameter int CW   = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          loadEn,
  input logic          regSel,
  input logic          regWr,
  input logic [7:0]    regWdata,
  input logic [7:0]    regRdata,
  input logic          xferAck,
  input logic          disableSel,
  input logic [CW-1:0] count,
  input logic          ovfFlag,
  input logic          unfFlag,
  input logic          dirUp
);
  localparam logic [CW-1:0] TOP = '1;

  a_r3_const_bits: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (regRdata[6] && regRdata[3:0] == 4'b0));

  a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rstN)
    ($past(count) == TOP && count == '0 && !$past(loadEn)) |-> ovfFlag);

  a_r5_unf_reserved: assert property (@(posedge clk) disable iff (!rstN)
    !(CHAN == 1 || CHAN == 2) |-> !unfFlag);

  a_r2_dir_ch0: assert property (@(posedge clk) disable iff (!rstN)
    (CHAN == 0) |-> dirUp);

  a_r7_ovf_clear_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |->
      $past(regWr && !regSel && !regWdata[4]) ||
      ((CHAN == 4) && $past(xferAck && !disableSel)));
endmodule

bind tmr_chan_status tmr_chan_status_chk #(.CHAN(CHAN), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .regSel(regSel), .regWr(regWr),
  .regWdata(regWdata), .regRdata(regRdata), .xferAck(xferAck),
  .disableSel(disableSel), .count(count), .ovfFlag(ovfFlag),
  .unfFlag(unfFlag), .dirUp(dirUp)
);

// File: tb/sim_tmr_chan_status.sv
module sim_tmr_chan_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntEnable = 0, countUp = 1, phaseMode = 0, cplPwmMode = 0, loadEn = 0;
  logic [15:0] loadValue = '0;
  logic regSel = 0, regRd = 0, regWr = 0, xferAck = 0, disableSel = 0;
  logic [7:0] regWdata = '0;
  logic [7:0] rd1, rd4, rd0;
  logic [15:0] cnt1, cnt4, cnt0;
  logic io1, iu1, io4, iu4, io0, iu0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_chan_status #(.CHAN(1)) u0 (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .countUp(countUp),
    .phaseMode(phaseMode), .cplPwmMode(cplPwmMode), .loadEn(loadEn),
    .loadValue(loadValue), .regSel(regSel), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(rd1), .xferAck(xferAck),
    .disableSel(disableSel), .count(cnt1), .irqOvf(io1), .irqUnf(iu1));
  tmr_chan_status #(.CHAN(4)) u4 (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .countUp(countUp),
    .phaseMode(phaseMode), .cplPwmMode(cplPwmMode), .loadEn(loadEn),
    .loadValue(loadValue), .regSel(regSel), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(rd4), .xferAck(xferAck),
    .disableSel(disableSel), .count(cnt4), .irqOvf(io4), .irqUnf(iu4));
  tmr_chan_status #(.CHAN(0)) uz (
    .clk(clk), .rstN(rstN), .cntEnable(cntEnable), .countUp(countUp),
    .phaseMode(phaseMode), .cplPwmMode(cplPwmMode), .loadEn(loadEn),
    .loadValue(loadValue), .regSel(regSel), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(rd0), .xferAck(xferAck),
    .disableSel(disableSel), .count(cnt0), .irqOvf(io0), .irqUnf(iu0));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadCnt(input logic [15:0] v);
    loadEn = 1; loadValue = v; tick(); loadEn = 0;
  endtask

  task automatic statRead();
    regSel = 0; regRd = 1; tick(); regRd = 0;
  endtask

  task automatic statWrite(input logic [7:0] d);
    regSel = 0; regWr = 1; regWdata = d; tick(); regWr = 0;
  endtask

  task automatic clearAll();
    statRead(); statWrite(8'h00);
  endtask

  task automatic t_reset();
    regSel = 0;
    chk("R1 status ch1", rd1, 8'hC0);
    chk("R1 status ch4", rd4, 8'hC0);
    chk("R1 status ch0", rd0, 8'hC0);
    chk("R1 count", cnt1, 0);
    chk("R1 irq", {io1, iu1, io4}, 0);
    regSel = 1; #0.1;
    chk("R1 enable reg", rd1, 8'h00);
    regSel = 0;
  endtask

  task automatic t_count();
    loadCnt(16'h0005);
    chk("R11 load", cnt1, 16'h0005);
    cntEnable = 1; countUp = 1; tick(); tick(); tick(); cntEnable = 0;
    chk("R11 count up", cnt1, 16'h0008);
    tick();
    chk("R11 hold", cnt1, 16'h0008);
  endtask

  task automatic t_ovf();
    loadCnt(16'hFFFE);
    cntEnable = 1; tick();
    chk("R4 no ovf at FFFF", rd1[4], 0);
    tick(); cntEnable = 0;
    chk("R4 count wrapped", cnt1, 16'h0000);
    chk("R4 ovf set", rd1[4], 1);
    chk("R3 fixed bits", {rd1[6], rd1[3:0]}, 5'h10);
  endtask

  task automatic t_clear();
    statWrite(8'h00);
    chk("R7 write without read", rd1[4], 1);
    statRead(); statWrite(8'hFF);
    chk("R7 write one", rd1[4], 1);
    statWrite(8'h00);
    chk("R7 arm used up", rd1[4], 1);
    statRead(); statWrite(8'h00);
    chk("R7 read then write zero", rd1[4], 0);
  endtask

  task automatic t_dir();
    phaseMode = 1; countUp = 0; loadCnt(16'h0003);
    cntEnable = 1; tick(); cntEnable = 0;
    chk("R2 down count", cnt1, 16'h0002);
    chk("R2 dir down ch1", rd1[7], 0);
    chk("R2 dir ch0 fixed", rd0[7], 1);
    statWrite(8'hFF);
    chk("R2 dir write ignored", rd1[7], 0);
    countUp = 1; cntEnable = 1; tick(); cntEnable = 0;
    chk("R2 dir up", rd1[7], 1);
    countUp = 0;
  endtask

  task automatic t_unf();
    loadCnt(16'h0001);
    cntEnable = 1; tick();
    chk("R5 no unf at zero", rd1[5], 0);
    tick(); cntEnable = 0;
    chk("R5 count FFFF", cnt1, 16'hFFFF);
    chk("R5 unf set ch1", rd1[5], 1);
    chk("R5 reserved ch4", rd4[5], 0);
    chk("R5 reserved ch0", rd0[5], 0);
    phaseMode = 0; countUp = 1;
    clearAll();
    chk("R7 unf cleared", rd1[5], 0);
  endtask

  task automatic t_cpl();
    clearAll();
    cplPwmMode = 1; countUp = 0; loadCnt(16'h0002);
    cntEnable = 1; tick();
    chk("R6 ch4 at one", {cnt4, rd4[4]}, {16'h0001, 1'b0});
    tick(); cntEnable = 0;
    chk("R6 ch4 ovf on 1->0", {cnt4, rd4[4]}, {16'h0000, 1'b1});
    chk("R6 ch1 unaffected", rd1[4], 0);
    cplPwmMode = 0; countUp = 1;
  endtask

  task automatic t_ack();
    xferAck = 1; disableSel = 1; tick();
    chk("R9 ack disabled", rd4[4], 1);
    disableSel = 0; tick(); xferAck = 0;
    chk("R9 ack clears", rd4[4], 0);
  endtask

  task automatic t_setwins();
    loadCnt(16'hFFFF);
    cntEnable = 1; tick(); cntEnable = 0;
    chk("R8 setup ovf", rd1[4], 1);
    statRead();
    loadCnt(16'hFFFF);
    cntEnable = 1; regSel = 0; regWr = 1; regWdata = 8'h00; tick();
    cntEnable = 0; regWr = 0;
    chk("R8 set wins", rd1[4], 1);
    clearAll();
    chk("R8 later clear", rd1[4], 0);
  endtask

  task automatic t_irq();
    loadCnt(16'hFFFF);
    cntEnable = 1; tick(); cntEnable = 0;
    chk("R10 irq masked", io1, 0);
    regSel = 1; regWr = 1; regWdata = 8'h01; tick(); regWr = 0;
    chk("R10 enable readback", rd1, 8'h01);
    chk("R10 irq ovf", {io1, iu1}, 2'b10);
    regSel = 0;
    clearAll();
    chk("R10 irq drops", io1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_ovf();
    t_clear();
    t_dir();
    t_unf();
    t_cpl();
    t_ack();
    t_setwins();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule